// File: doc/BRIEF.md
# Coalesced Hybrid Load Value Predictor

This block guesses the value a load will return before memory answers. It is a direct-mapped table. A load's PC picks one line, and each line holds a short partial tag, a flag recording a recent tag miss, the newest loaded value at full 64-bit width, and the low 20 bits of the two values before it. The two older values are rebuilt by taking the upper 44 bits of the newest value.

From one line the block forms five candidates:

- a stride guess, computed as twice the newest value minus the rebuilt second value;
- the current contents of the load's destination register;
- the three remembered values.

A confidence level for each candidate comes in on a port from estimator arrays outside the block. The candidate with the most confidence is chosen, and a prediction is raised only when the tag matches and that confidence reaches a fixed threshold. The lookup path is purely combinational.

Updates are applied at the clock edge with the PC and the value the load actually returned. When the tag matches, the stored values age by one slot. When it does not match, the first miss only sets the line's miss flag. A second consecutive miss hands the line to the new load. This keeps rarely executed loads from evicting useful entries.

Top module: `lvp_coalesced`

## Requirements
- R1: After reset every line holds tag 0, a clear miss flag and all-zero values.
- R2: The line index is PC bits [11:2] and the partial tag is PC bits [19:12]. Other PC bits have no effect.
- R3: When the stored tag differs from the lookup tag, pred_take_o is 0 and pred_value_o is 0.
- R4: With a matching tag, pred_take_o is 1 only if the largest of the five confidences is at least CONF_MIN (default 8). Otherwise pred_take_o and pred_value_o are both 0.
- R5: The confidence port packs five 4-bit lanes: bits [3:0] stride, [7:4] register, [11:8] newest value, [15:12] second value, [19:16] third value.
- R6: The stride candidate is 2*newest − rebuilt second value, modulo 2^64.
- R7: The register candidate is lk_reg_val unchanged.
- R8: An older value is rebuilt as {newest[63:20], stored 20-bit part}.
- R9: The candidate with the strictly greatest confidence is chosen. On equal confidence the lower lane wins, in the order stride, register, newest, second, third.
- R10: An update whose tag matches moves the second part into the third, the newest value's low 20 bits into the second, writes the true value as newest, and clears the miss flag.
- R11: An update that misses on a line with a clear miss flag only sets that flag. Tag and values stay as they were.
- R12: An update that misses on a line whose miss flag is set writes the new tag, sets newest to the true value and both parts to its low 20 bits, and clears the flag.
- R13: A matching update between two misses clears the flag, so the following miss does not replace the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | 64 | PC of the load being looked up |
| lk_reg_val | input | 64 | Current contents of the load's destination register |
| lk_conf | input | 20 | Five 4-bit confidence lanes (layout in R5) |
| pred_take_o | output | 1 | Prediction should be used |
| pred_value_o | output | 64 | Predicted value, zero when not taken |
| upd_en | input | 1 | Apply an update at this clock edge |
| upd_pc | input | 64 | PC of the load being retired |
| upd_value | input | 64 | Value the load actually returned |

## Verification
The bench concentrates on the replacement filter.

- It runs a single miss, two misses in a row, and a miss–hit–miss pattern. A design that replaced on the first miss, or kept a stale flag, would lose the resident line too early or too late.
- It builds older values whose upper bits differ from the newest value's. A design that stored or added offsets instead of splicing bits would return wrong words.
- It uses stride sequences that go negative and confidence ties at every lane pair. These expose a sign or width slip in the subtraction and an inverted tie order.
- It puts the maximum confidence at exactly 7 and 8. An off-by-one threshold would flip the predict flag.

// File: rtl/lvp_pkg.sv
// Shared widths, lane numbering and the table line layout for the
// coalesced load value predictor. Assumes older values differ from the
// newest value only in their low PART_W bits.
package lvp_pkg;
    localparam int VAL_W   = 64;
    localparam int PART_W  = 20;
    localparam int HI_W    = VAL_W - PART_W;
    localparam int TAG_W   = 8;
    localparam int CONF_W  = 4;
    localparam int NCOMP   = 5;
    localparam int SEL_W   = $clog2(NCOMP);
    localparam int ALIGN_W = 2;

    // Candidate lanes, also the tie-break priority (low index wins)
    localparam int L_STRIDE = 0;
    localparam int L_REG    = 1;
    localparam int L_NEW    = 2;
    localparam int L_OLD2   = 3;
    localparam int L_OLD3   = 4;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic              missed;
        logic [VAL_W-1:0]  newest;
        logic [PART_W-1:0] old2;
        logic [PART_W-1:0] old3;
    } line_t;

    // Rebuild a full older value from the newest value's upper bits
    function automatic logic [VAL_W-1:0] splice(input logic [VAL_W-1:0] nv,
                                                input logic [PART_W-1:0] part);
        return {nv[VAL_W-1:PART_W], part};
    endfunction
endpackage

// File: rtl/lvp_line_store.sv
// Direct-mapped line storage: two combinational read ports (lookup and
// update) and one synchronous write port. Every line clears on reset.
module lvp_line_store
    import lvp_pkg::*;
#(
    parameter int LINES = 1024,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output line_t            rd_a,
    input  logic [IDX_W-1:0] rd_b_idx,
    output line_t            rd_b,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_t            wr_data
);
    line_t mem [LINES];

    // Read ports: asynchronous so lookup sees state before the edge
    assign rd_a = mem[rd_a_idx];
    assign rd_b = mem[rd_b_idx];

    // Write port: clear all lines on reset, else store one line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/lvp_update_ctl.sv
// Computes the next contents of a line from its current contents and one
// retiring load: ages values on a tag match, otherwise applies the
// two-miss replacement filter. Purely combinational.
module lvp_update_ctl
    import lvp_pkg::*;
(
    input  logic             upd_en,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic [VAL_W-1:0] upd_value,
    input  line_t            cur,
    output logic             wr_en,
    output line_t            nxt
);
    // Next-line selection: age, mark first miss, or replace
    always_comb begin
        nxt   = cur;
        wr_en = upd_en;
        if (cur.tag == upd_tag) begin
            nxt.old3   = cur.old2;
            nxt.old2   = cur.newest[PART_W-1:0];
            nxt.newest = upd_value;
            nxt.missed = 1'b0;
        end else if (cur.missed) begin
            nxt.tag    = upd_tag;
            nxt.newest = upd_value;
            nxt.old2   = upd_value[PART_W-1:0];
            nxt.old3   = upd_value[PART_W-1:0];
            nxt.missed = 1'b0;
        end else begin
            nxt.missed = 1'b1;
        end
    end
endmodule

// File: rtl/lvp_cand_gen.sv
// Builds the five candidate values from one line and the register value.
// The stride lane needs no stored offset: it is derived from the newest
// and rebuilt second values.
module lvp_cand_gen
    import lvp_pkg::*;
(
    input  line_t                        line,
    input  logic [VAL_W-1:0]             reg_val,
    output logic [NCOMP-1:0][VAL_W-1:0]  cand
);
    logic [VAL_W-1:0] full2;
    logic             unused_meta;

    assign unused_meta = ^{line.tag, line.missed};

    // Candidate formation for every lane
    always_comb begin
        full2          = splice(line.newest, line.old2);
        cand[L_STRIDE] = (line.newest << 1) - full2;
        cand[L_REG]    = reg_val;
        cand[L_NEW]    = line.newest;
        cand[L_OLD2]   = full2;
        cand[L_OLD3]   = splice(line.newest, line.old3);
    end
endmodule

// File: rtl/lvp_pick.sv
// Chooses the lane with the greatest confidence, earlier lanes winning
// ties, and raises take when the tag hit and the winner meets CONF_MIN.
module lvp_pick
    import lvp_pkg::*;
#(
    parameter int CONF_MIN = 8
) (
    input  logic [NCOMP-1:0][CONF_W-1:0] conf,
    input  logic                         hit,
    output logic                         take,
    output logic [SEL_W-1:0]             sel
);
    logic [CONF_W-1:0] best_c [NCOMP];
    logic [SEL_W-1:0]  best_i [NCOMP];

    assign best_c[0] = conf[0];
    assign best_i[0] = '0;

    // Linear scan: a later lane replaces the leader only if strictly larger
    for (genvar k = 1; k < NCOMP; k++) begin : g_scan
        assign best_c[k] = (conf[k] > best_c[k-1]) ? conf[k] : best_c[k-1];
        assign best_i[k] = (conf[k] > best_c[k-1]) ? SEL_W'(k) : best_i[k-1];
    end

    assign sel  = best_i[NCOMP-1];
    assign take = hit && (best_c[NCOMP-1] >= CONF_W'(CONF_MIN));
endmodule

// File: rtl/lvp_coalesced.sv
// Top of the coalesced hybrid load value predictor. Lookup is
// combinational from the lookup ports; updates land at the clock edge.
// Assumes confidence lanes are supplied externally and CONF_MIN fits in
// a confidence lane.
module lvp_coalesced
    import lvp_pkg::*;
#(
    parameter int LINES    = 1024,
    parameter int PC_W     = 64,
    parameter int CONF_MIN = 8,
    localparam int IDX_W   = $clog2(LINES),
    localparam int TAG_LO  = ALIGN_W + IDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PC_W-1:0]         lk_pc,
    input  logic [VAL_W-1:0]        lk_reg_val,
    input  logic [NCOMP*CONF_W-1:0] lk_conf,
    output logic                    pred_take_o,
    output logic [VAL_W-1:0]        pred_value_o,
    input  logic                    upd_en,
    input  logic [PC_W-1:0]         upd_pc,
    input  logic [VAL_W-1:0]        upd_value
);
    logic [IDX_W-1:0]               lk_idx, up_idx;
    logic [TAG_W-1:0]               lk_tag, up_tag;
    line_t                          look_line, upd_cur, wr_data;
    logic                           wr_en;
    logic [NCOMP-1:0][VAL_W-1:0]    cand;
    logic [NCOMP-1:0][CONF_W-1:0]   conf_v;
    logic [SEL_W-1:0]               sel_idx;
    logic                           take;
    logic                           unused_pc;

    assign lk_idx = lk_pc[ALIGN_W +: IDX_W];
    assign lk_tag = lk_pc[TAG_LO +: TAG_W];
    assign up_idx = upd_pc[ALIGN_W +: IDX_W];
    assign up_tag = upd_pc[TAG_LO +: TAG_W];
    assign conf_v = lk_conf;
    assign unused_pc = ^{lk_pc[PC_W-1:TAG_LO+TAG_W], lk_pc[ALIGN_W-1:0],
                         upd_pc[PC_W-1:TAG_LO+TAG_W], upd_pc[ALIGN_W-1:0]};

    lvp_line_store #(.LINES(LINES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (lk_idx),
        .rd_a     (look_line),
        .rd_b_idx (up_idx),
        .rd_b     (upd_cur),
        .wr_en    (wr_en),
        .wr_idx   (up_idx),
        .wr_data  (wr_data)
    );

    lvp_update_ctl u_upd (
        .upd_en    (upd_en),
        .upd_tag   (up_tag),
        .upd_value (upd_value),
        .cur       (upd_cur),
        .wr_en     (wr_en),
        .nxt       (wr_data)
    );

    lvp_cand_gen u_cand (
        .line    (look_line),
        .reg_val (lk_reg_val),
        .cand    (cand)
    );

    lvp_pick #(.CONF_MIN(CONF_MIN)) u_pick (
        .conf (conf_v),
        .hit  (look_line.tag == lk_tag),
        .take (take),
        .sel  (sel_idx)
    );

    // Output gating: zero value unless a prediction is made
    always_comb begin
        pred_take_o  = take;
        pred_value_o = take ? cand[sel_idx] : '0;
    end
endmodule

// File: rtl/lvp_coalesced_chk.sv
// Property checker for lvp_coalesced, attached by bind below. Watches the
// lookup ports, the chosen lane and the line write produced per update.
module lvp_coalesced_chk
    import lvp_pkg::*;
#(
    parameter int LINES    = 1024,
    parameter int PC_W     = 64,
    parameter int CONF_MIN = 8,
    localparam int IDX_W   = $clog2(LINES),
    localparam int TAG_LO  = ALIGN_W + IDX_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [PC_W-1:0]         lk_pc,
    input logic [NCOMP*CONF_W-1:0] lk_conf,
    input logic                    pred_take_o,
    input logic [VAL_W-1:0]        pred_value_o,
    input line_t                   look_line,
    input logic [SEL_W-1:0]        sel_idx,
    input logic                    upd_en,
    input logic [PC_W-1:0]         upd_pc,
    input logic [VAL_W-1:0]        upd_value,
    input line_t                   upd_cur,
    input logic                    wr_en,
    input line_t                   wr_data
);
    logic [NCOMP-1:0][CONF_W-1:0] cv;
    logic [CONF_W-1:0]            sel_conf;
    logic                         beaten, tied_earlier;
    logic [TAG_W-1:0]             lt, ut;
    logic                         unused_chk;

    assign cv  = lk_conf;
    assign lt  = lk_pc[TAG_LO +: TAG_W];
    assign ut  = upd_pc[TAG_LO +: TAG_W];
    assign unused_chk = ^{lk_pc, upd_pc, look_line.missed, look_line.newest,
                          look_line.old2, look_line.old3};

    // Compare the chosen lane against all others
    always_comb begin
        sel_conf     = cv[sel_idx];
        beaten       = 1'b0;
        tied_earlier = 1'b0;
        for (int k = 0; k < NCOMP; k++) begin
            if (cv[k] > sel_conf) beaten = 1'b1;
            if (k < int'(sel_idx) && cv[k] == sel_conf) tied_earlier = 1'b1;
        end
    end

    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_take_o |-> pred_value_o == '0);
    p_tag_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_take_o |-> look_line.tag == lt);
    p_threshold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pred_take_o |-> sel_conf >= CONF_W'(CONF_MIN));
    p_max_conf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pred_take_o |-> !beaten && !tied_earlier);
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |-> !wr_en);
    p_age_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_cur.tag == ut) |->
        (wr_en && wr_data.newest == upd_value &&
         wr_data.old2 == upd_cur.newest[PART_W-1:0] &&
         wr_data.old3 == upd_cur.old2 && !wr_data.missed));
    p_first_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_cur.tag != ut && !upd_cur.missed) |->
        (wr_data.tag == upd_cur.tag && wr_data.newest == upd_cur.newest &&
         wr_data.old2 == upd_cur.old2 && wr_data.old3 == upd_cur.old3 &&
         wr_data.missed));
    p_replace_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_cur.tag != ut && upd_cur.missed) |->
        (wr_data.tag == ut && wr_data.newest == upd_value &&
         wr_data.old2 == upd_value[PART_W-1:0] &&
         wr_data.old3 == upd_value[PART_W-1:0] && !wr_data.missed));
endmodule

bind lvp_coalesced lvp_coalesced_chk #(
    .LINES(LINES), .PC_W(PC_W), .CONF_MIN(CONF_MIN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_pc        (lk_pc),
    .lk_conf      (lk_conf),
    .pred_take_o  (pred_take_o),
    .pred_value_o (pred_value_o),
    .look_line    (look_line),
    .sel_idx      (sel_idx),
    .upd_en       (upd_en),
    .upd_pc       (upd_pc),
    .upd_value    (upd_value),
    .upd_cur      (upd_cur),
    .wr_en        (wr_en),
    .wr_data      (wr_data)
);

// File: tb/lvp_coalesced_test.sv
`timescale 1ns/1ps
// Bench for lvp_coalesced: directed corner cases then seeded random
// traffic, each lookup compared against a requirement-level model.
module lvp_coalesced_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] lk_pc = '0, lk_reg_val = '0, upd_pc = '0, upd_value = '0;
    logic [19:0] lk_conf = '0;
    logic        upd_en = 1'b0;
    logic        pred_take_o;
    logic [63:0] pred_value_o;

    int n_chk = 0, n_bad = 0;

    // model state, per R1 cleared at reset
    logic [7:0]  m_tag  [1024];
    logic        m_miss [1024];
    logic [63:0] m_new  [1024];
    logic [19:0] m_o2   [1024];
    logic [19:0] m_o3   [1024];

    always #2 clk = ~clk;

    lvp_coalesced uut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_reg_val(lk_reg_val),
        .lk_conf(lk_conf), .pred_take_o(pred_take_o),
        .pred_value_o(pred_value_o), .upd_en(upd_en), .upd_pc(upd_pc),
        .upd_value(upd_value)
    );

    // R2: index in PC[11:2], tag in PC[19:12]
    function automatic logic [63:0] mk_pc(input int idx, input int tag);
        return (64'(tag) << 12) | (64'(idx) << 2);
    endfunction

    // R5: lane packing
    function automatic logic [19:0] cf(input int s, input int r, input int n,
                                       input int o2, input int o3);
        return {4'(o3), 4'(o2), 4'(n), 4'(r), 4'(s)};
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp,
                       input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference lookup from R3..R9
    task automatic model_look(input logic [63:0] pc, input logic [63:0] rv,
                              input logic [19:0] c, output logic tk,
                              output logic [63:0] v);
        int idx = int'(pc[11:2]);
        logic [63:0] cands [5];
        logic [63:0] f2;
        int best = 0;
        f2 = {m_new[idx][63:20], m_o2[idx]};
        cands[0] = 2 * m_new[idx] - f2;
        cands[1] = rv;
        cands[2] = m_new[idx];
        cands[3] = f2;
        cands[4] = {m_new[idx][63:20], m_o3[idx]};
        for (int k = 1; k < 5; k++)
            if (c[k*4 +: 4] > c[best*4 +: 4]) best = k;
        tk = (m_tag[idx] == pc[19:12]) && (c[best*4 +: 4] >= 4'd8);
        v  = tk ? cands[best] : 64'd0;
    endtask

    // Reference update from R10..R13
    task automatic model_upd(input logic [63:0] pc, input logic [63:0] val);
        int idx = int'(pc[11:2]);
        if (m_tag[idx] == pc[19:12]) begin
            m_o3[idx] = m_o2[idx];
            m_o2[idx] = m_new[idx][19:0];
            m_new[idx] = val;
            m_miss[idx] = 1'b0;
        end else if (m_miss[idx]) begin
            m_tag[idx] = pc[19:12];
            m_new[idx] = val;
            m_o2[idx] = val[19:0];
            m_o3[idx] = val[19:0];
            m_miss[idx] = 1'b0;
        end else begin
            m_miss[idx] = 1'b1;
        end
    endtask

    // One cycle: drive lookup and optional update, check lookup result
    task automatic step(input logic [63:0] pc, input logic [63:0] rv,
                        input logic [19:0] c, input logic ue,
                        input logic [63:0] upc, input logic [63:0] uv,
                        input string req);
        logic tk;
        logic [63:0] v;
        @(negedge clk);
        lk_pc = pc; lk_reg_val = rv; lk_conf = c;
        upd_en = ue; upd_pc = upc; upd_value = uv;
        #1;
        model_look(pc, rv, c, tk, v);
        chk(64'(pred_take_o), 64'(tk), {req, " take"});
        chk(pred_value_o, v, {req, " value"});
        if (ue) model_upd(upc, uv);
    endtask

    task automatic look(input logic [63:0] pc, input logic [63:0] rv,
                        input logic [19:0] c, input string req);
        step(pc, rv, c, 1'b0, '0, '0, req);
    endtask

    task automatic upd(input logic [63:0] pc, input logic [63:0] v);
        step(64'hFFFF_0000, '0, '0, 1'b1, pc, v, "upd");
    endtask

    // Directed lookup against a hand-computed value
    task automatic expect_val(input logic [63:0] pc, input logic [63:0] rv,
                              input logic [19:0] c, input logic tk,
                              input logic [63:0] v, input string req);
        look(pc, rv, c, req);
        chk(64'(pred_take_o), 64'(tk), {req, " hand take"});
        chk(pred_value_o, v, {req, " hand value"});
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] a, b, c;
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) begin
            m_tag[i] = '0; m_miss[i] = 1'b0; m_new[i] = '0;
            m_o2[i] = '0; m_o3[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1/R3: reset lines carry tag 0; tag 5 misses, tag 0 hits zeros
        expect_val(mk_pc(3, 5), 64'h77, cf(15,15,15,15,15), 1'b0, 64'd0, "R1 R3 miss after reset");
        expect_val(mk_pc(3, 0), 64'h77, cf(0,0,15,0,0), 1'b1, 64'd0, "R1 zero line");
        // R7: register lane passes lk_reg_val
        expect_val(mk_pc(3, 0), 64'hDEAD_BEEF_0123_4567, cf(0,9,0,0,0), 1'b1,
                   64'hDEAD_BEEF_0123_4567, "R7 register lane");

        // R11/R12: first miss keeps line, second replaces
        a = 64'h1234_5678_9ABC_DEF0;
        upd(mk_pc(7, 3), a);
        expect_val(mk_pc(7, 3), 0, cf(0,0,15,0,0), 1'b0, 64'd0, "R11 first miss no replace");
        expect_val(mk_pc(7, 0), 0, cf(0,0,15,0,0), 1'b1, 64'd0, "R11 old owner kept");
        upd(mk_pc(7, 3), a);
        expect_val(mk_pc(7, 3), 0, cf(0,0,15,0,0), 1'b1, a, "R12 replaced newest");
        expect_val(mk_pc(7, 3), 0, cf(0,0,0,15,0), 1'b1, a, "R12 second part");
        expect_val(mk_pc(7, 3), 0, cf(0,0,0,0,15), 1'b1, a, "R12 third part");
        expect_val(mk_pc(7, 0), 0, cf(0,0,15,0,0), 1'b0, 64'd0, "R12 old owner gone");

        // R10/R8: aging and splice with differing upper bits
        b = 64'h1234_5678_9AB0_0001;
        c = 64'hAAAA_BBBB_CCCC_DDDD;
        upd(mk_pc(7, 3), b);
        upd(mk_pc(7, 3), c);
        expect_val(mk_pc(7, 3), 0, cf(0,0,12,0,0), 1'b1, c, "R10 newest");
        expect_val(mk_pc(7, 3), 0, cf(0,0,0,12,0), 1'b1, 64'hAAAA_BBBB_CCC0_0001, "R8 R10 second");
        expect_val(mk_pc(7, 3), 0, cf(0,0,0,0,12), 1'b1, 64'hAAAA_BBBB_CCCC_DEF0, "R8 R10 third");

        // R2: low alignment bits and bits above the tag ignored
        expect_val(mk_pc(7, 3) | 64'h3 | 64'hABCD_0000_0000_0000, 0, cf(0,0,12,0,0),
                   1'b1, c, "R2 ignored PC bits");

        // R6: stride, including a negative step
        upd(mk_pc(20, 1), 64'd100);
        upd(mk_pc(20, 1), 64'd100);
        upd(mk_pc(20, 1), 64'd130);
        expect_val(mk_pc(20, 1), 0, cf(10,0,0,0,0), 1'b1, 64'd160, "R6 stride up");
        upd(mk_pc(20, 1), 64'd90);
        upd(mk_pc(20, 1), 64'd10);
        expect_val(mk_pc(20, 1), 0, cf(10,0,0,0,0), 1'b1, 64'hFFFF_FFFF_FFFF_FFBA, "R6 stride negative");

        // R9: greatest confidence wins, ties to the lower lane
        expect_val(mk_pc(20, 1), 64'h55, cf(9,9,9,9,9), 1'b1, 64'hFFFF_FFFF_FFFF_FFBA, "R9 tie stride");
        expect_val(mk_pc(20, 1), 64'h55, cf(3,9,9,9,9), 1'b1, 64'h55, "R9 tie register");
        expect_val(mk_pc(20, 1), 64'h55, cf(3,2,9,9,9), 1'b1, 64'd10, "R9 tie newest");
        expect_val(mk_pc(20, 1), 64'h55, cf(3,2,1,9,9), 1'b1, 64'd90, "R9 tie second");
        expect_val(mk_pc(20, 1), 64'h55, cf(3,2,1,9,10), 1'b1, 64'd130, "R9 max third");

        // R4: threshold boundary 7 versus 8
        expect_val(mk_pc(20, 1), 64'h55, cf(7,7,7,7,7), 1'b0, 64'd0, "R4 below threshold");
        expect_val(mk_pc(20, 1), 64'h55, cf(0,8,0,0,0), 1'b1, 64'h55, "R4 at threshold");

        // R13: miss, hit, miss keeps owner; next miss replaces
        upd(mk_pc(9, 2), 64'd1);
        upd(mk_pc(9, 0), 64'd5);
        upd(mk_pc(9, 2), 64'd6);
        expect_val(mk_pc(9, 0), 0, cf(0,0,15,0,0), 1'b1, 64'd5, "R13 owner kept");
        expect_val(mk_pc(9, 2), 0, cf(0,0,15,0,0), 1'b0, 64'd0, "R13 no replace");
        upd(mk_pc(9, 2), 64'd7);
        expect_val(mk_pc(9, 2), 0, cf(0,0,15,0,0), 1'b1, 64'd7, "R13 then replace");

        // Random traffic over a few colliding lines, all requirements
        for (int i = 0; i < 4000; i++) begin
            int li = 40 + int'($urandom_range(0, 3));
            int lt = int'($urandom_range(0, 2));
            int ui = 40 + int'($urandom_range(0, 3));
            int ut = int'($urandom_range(0, 2));
            logic [63:0] rv = {$urandom, $urandom};
            logic [63:0] uv;
            case ($urandom_range(0, 2))
                0: uv = 64'(i * 3);
                1: uv = {32'h0BAD_F00D, 12'h0, 20'($urandom)};
                default: uv = {$urandom, $urandom};
            endcase
            step(mk_pc(li, lt) | 64'($urandom_range(0, 3)), rv, 20'($urandom),
                 ($urandom_range(0, 9) < 7), mk_pc(ui, ut), uv, "R9 R10 random");
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule